// File: doc/BRIEF.md
# Background Pixel Alpha Modifier

This block sits on the background pixel path of a 2D graphics blitter. A 32-bit control word holds a constant alpha, an alpha policy selector and a lookup-table size. Each background pixel arrives as ARGB8888 on a valid/ready stream. The block leaves the pixel's alpha unchanged, replaces it with the constant, or scales it by the constant, according to the selected policy. The colour channels pass through untouched. The result comes out one register stage later on a second valid/ready stream.

Software, or a sequencer, programs the control word through a simple write/read port. Two inputs tell the block when configuration must stay frozen. While a pixel transfer runs, the constant alpha and the policy ignore writes. While a lookup-table load runs, the size field ignores writes. Ignored writes leave the stored values readable. The block also gives a downstream table loader the decoded entry count, which is the stored size plus one.

Top module: `bg_alpha_mod`

## Requirements
- R1: After a synchronous active-low reset, `cfg_rdata` reads 0, `lut_entries` is 1, `out_valid` is 0 and `in_ready` is 1.
- R2: The control word places the constant alpha in bits 31:24, the policy in bits 17:16 and the table size in bits 15:8. All other bits read back as 0, whatever was written to them.
- R3: Policy 00 passes the incoming alpha (pixel bits 31:24) through unchanged.
- R4: Policy 01 sets the outgoing alpha to the constant alpha.
- R5: Policy 10 sets the outgoing alpha to t = a*c + 128, then (t + (t >> 8)) >> 8, where a is the incoming alpha and c is the constant. This is a*c/255 rounded to nearest: 255 with 255 gives 255, and 0 with any value gives 0.
- R6: Policy 11 behaves exactly like policy 00.
- R7: Pixel bits 23:0 reach the output unchanged.
- R8: While `xfer_active` is 1, writes leave the constant alpha and the policy unchanged, both in read-back and in the processing of pixels. The size field still accepts the write.
- R9: While `lut_busy` is 1, writes leave the size field unchanged. The alpha and policy fields still accept the write.
- R10: `lut_entries` (9 bits) equals the stored size field plus 1, so it ranges from 1 to 256.
- R11: An input pixel is taken when `in_valid` and `in_ready` are both high at a clock edge. The resulting output is presented on the following cycle. The output holds valid and stable while `out_ready` is low. `in_ready` is high whenever the stage is empty or the output is being taken, and no pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| xfer_active | input | 1 | Pixel transfer running; locks alpha and policy |
| lut_busy | input | 1 | Lookup-table load running; locks size field |
| lut_entries | output | 9 | Decoded table entry count (size + 1) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can take a pixel |
| in_pixel | input | 32 | Input ARGB8888 pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_pixel | output | 32 | Output ARGB8888 pixel |

## Verification
The assertions assume several things about the inputs. The reset input is low for at least one edge before traffic starts. `in_pixel` is held stable while `in_valid` waits for `in_ready`. The lock inputs are treated as plain levels, sampled at the same edge as the write strobe. The stimulus meets these assumptions in four ways. A single task drives each pixel and keeps it steady until it is taken. Configuration writes and lock changes happen only at falling edges. `out_ready` follows a fixed irregular pattern, so the output sees both stalls and back-to-back transfers. For each of the four policies, the sweep uses every incoming alpha value against nine constants, including 0, 1, 128, 254 and 255.

// File: rtl/bgam_pkg.sv
// Package: shared widths, field positions and policy codes of the
// background alpha modifier. Field positions are fixed because the
// control word is decoded by software at these offsets.
package bgam_pkg;
    localparam int WORD_W   = 32;
    localparam int ALPHA_W  = 8;
    localparam int SIZE_W   = 8;
    localparam int MODE_W   = 2;
    localparam int ALPHA_LO = 24;
    localparam int MODE_LO  = 16;
    localparam int SIZE_LO  = 8;

    typedef enum logic [MODE_W-1:0] {
        POL_KEEP    = 2'b00,
        POL_REPLACE = 2'b01,
        POL_SCALE   = 2'b10,
        POL_UNDEF   = 2'b11
    } policy_e;
endpackage

// File: rtl/bgam_cfg_reg.sv
// Control word storage. Holds constant alpha, policy and table size.
// Assumes: the lock inputs are levels sampled on the same edge as cfg_we.
// Reserved bits are not stored and read as zero.
module bgam_cfg_reg
    import bgam_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ALPHA_W,
    parameter int SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          xfer_active,
    input  logic          lut_busy,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] const_alpha,
    output policy_e       policy,
    output logic [SW:0]   entries
);
    logic [AW-1:0]     alpha_q;
    logic [MODE_W-1:0] mode_q;
    logic [SW-1:0]     size_q;

    // Alpha/policy fields: written only when no transfer runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alpha_q <= '0;
            mode_q  <= '0;
        end else if (we && !xfer_active) begin
            alpha_q <= wdata[ALPHA_LO +: AW];
            mode_q  <= wdata[MODE_LO +: MODE_W];
        end
    end

    // Size field: written only when no table load runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if (we && !lut_busy) begin
            size_q <= wdata[SIZE_LO +: SW];
        end
    end

    // Read-back assembly with reserved bits forced to zero
    always_comb begin
        rdata = '0;
        rdata[ALPHA_LO +: AW]    = alpha_q;
        rdata[MODE_LO +: MODE_W] = mode_q;
        rdata[SIZE_LO +: SW]     = size_q;
    end

    assign const_alpha = alpha_q;
    assign policy      = policy_e'(mode_q);
    assign entries     = {1'b0, size_q} + {{SW{1'b0}}, 1'b1};

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));
    // R8
    xfer_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |=> ($stable(alpha_q) && $stable(mode_q)));
    // R9
    lut_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lut_busy |=> $stable(size_q));
    // R10
    entries_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entries != '0);
endmodule

// File: rtl/bgam_alpha_unit.sv
// Combinational alpha policy: keep, replace or scale by a constant.
// Assumes: policy code 11 carries no meaning and is mapped to keep.
// Scaling rounds a*c/255 to nearest with one add-shift correction.
module bgam_alpha_unit
    import bgam_pkg::*;
#(
    parameter int AW = ALPHA_W
) (
    input  logic [AW-1:0] pix_alpha,
    input  logic [AW-1:0] const_alpha,
    input  policy_e       policy,
    output logic [AW-1:0] new_alpha
);
    localparam int PW = 2 * AW + 1;
    localparam logic [PW-1:0] HALF = PW'(1) << (AW - 1);

    logic [PW-1:0] prod;
    logic [PW-1:0] biased;
    logic [PW-1:0] corrected;
    logic [AW-1:0] scaled;

    // Rounded product of the two alphas, normalised back to AW bits
    always_comb begin
        prod      = PW'(pix_alpha) * PW'(const_alpha);
        biased    = prod + HALF;
        corrected = biased + (biased >> AW);
        scaled    = corrected[AW +: AW];
    end

    // Policy selection; undefined code behaves as keep
    always_comb begin
        unique case (policy)
            POL_REPLACE: new_alpha = const_alpha;
            POL_SCALE:   new_alpha = scaled;
            default:     new_alpha = pix_alpha;
        endcase
    end

    // R5
    always_comb begin
        if (!$isunknown({pix_alpha, const_alpha})) begin
            scale_bound_chk: assert (scaled <= pix_alpha && scaled <= const_alpha);
        end
    end
endmodule

// File: rtl/bgam_pix_stage.sv
// Single register slice with valid/ready handshake.
// Assumes: upstream holds data stable while valid waits for ready.
// Accepts a new pixel in the same cycle the held one is consumed.
module bgam_pix_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign s_ready = !vld_q || m_ready;

    // Load on acceptance, clear when drained with no new pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (s_ready) begin
            vld_q <= s_valid;
            if (s_valid) dat_q <= s_data;
        end
    end

    assign m_valid = vld_q;
    assign m_data  = dat_q;

    // R11
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
    // R11
    accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid);
endmodule

// File: rtl/bg_alpha_mod.sv
// Top: background pixel alpha modifier. Applies the configured alpha
// policy to each ARGB8888 pixel and registers the result once.
// Assumes: config changes take effect on pixels accepted after the write edge.
module bg_alpha_mod
    import bgam_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ALPHA_W,
    parameter int SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          xfer_active,
    input  logic          lut_busy,
    output logic [SW:0]   lut_entries,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_pixel,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_pixel
);
    localparam int CW = DW - AW;

    logic [AW-1:0] const_alpha;
    policy_e       policy;
    logic [AW-1:0] new_alpha;
    logic [DW-1:0] mod_pixel;

    bgam_cfg_reg #(.DW(DW), .AW(AW), .SW(SW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .wdata       (cfg_wdata),
        .xfer_active (xfer_active),
        .lut_busy    (lut_busy),
        .rdata       (cfg_rdata),
        .const_alpha (const_alpha),
        .policy      (policy),
        .entries     (lut_entries)
    );

    bgam_alpha_unit #(.AW(AW)) u_alpha (
        .pix_alpha   (in_pixel[DW-1 -: AW]),
        .const_alpha (const_alpha),
        .policy      (policy),
        .new_alpha   (new_alpha)
    );

    // Reassemble pixel: new alpha on top, colour channels untouched
    assign mod_pixel = {new_alpha, in_pixel[CW-1:0]};

    bgam_pix_stage #(.W(DW)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (in_valid),
        .s_ready (in_ready),
        .s_data  (mod_pixel),
        .m_valid (out_valid),
        .m_ready (out_ready),
        .m_data  (out_pixel)
    );

    // R7
    colour_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_pixel[CW-1:0] == $past(in_pixel[CW-1:0])));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && lut_entries == 9'd1));
endmodule

// File: tb/bg_alpha_mod_bench.sv
module bg_alpha_mod_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xfer_active = 1'b0;
    logic        lut_busy = 1'b0;
    logic [8:0]  lut_entries;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pixel;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int cyc = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_pix = '0;

    always #2.5 clk = ~clk;

    bg_alpha_mod u_bg_alpha_mod (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_active(xfer_active), .lut_busy(lut_busy),
        .lut_entries(lut_entries), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel)
    );

    // Irregular downstream readiness pattern
    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= !rst_n || (((cyc % 7) != 3) && ((cyc % 5) != 1));
    end

    function automatic logic [7:0] ref_alpha(input logic [1:0] pol,
                                             input logic [7:0] c, input logic [7:0] a);
        int p;
        p = int'(a) * int'(c);
        case (pol)
            2'b01:   return c;
            2'b10:   return 8'((2 * p + 255) / 510);
            default: return a;
        endcase
    endfunction

    function automatic string pol_tag(input logic [1:0] pol);
        case (pol)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Output monitor: compares taken pixels and checks hold under stall
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check("R11 hold", {31'(out_valid), out_pixel[0]}, {31'd1, prev_pix[0]});
                check("R11 data", out_pixel, prev_pix);
            end
            prev_stall = out_valid && !out_ready;
            prev_pix   = out_pixel;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R11 extra", out_pixel, 32'hxxxx_xxxx);
                end else begin
                    check(tag_q.pop_front(), out_pixel, exp_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] p, input logic [31:0] e, input string tag);
        in_pixel = p;
        in_valid = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] word(input logic [7:0] a, input logic [1:0] m, input logic [7:0] s);
        return {a, 6'b0, m, s, 8'h00};
    endfunction

    logic [7:0] consts [9] = '{8'd0, 8'd1, 8'd2, 8'd64, 8'd127, 8'd128, 8'd200, 8'd254, 8'd255};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", cfg_rdata, 32'h0);
        check("R1 entries", 32'(lut_entries), 32'd1);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd1);

        // R2 field layout and reserved bits; R10 entry decode
        wr(32'hA5FF_3CFF);
        check("R2 readback", cfg_rdata, 32'hA503_3C00);
        check("R10 entries", 32'(lut_entries), 32'd61);
        wr(word(8'h00, 2'b00, 8'hFF));
        check("R10 max", 32'(lut_entries), 32'd256);
        wr(word(8'h00, 2'b00, 8'h00));
        check("R10 min", 32'(lut_entries), 32'd1);

        // Sweep: every policy, nine constants, all 256 incoming alphas (R3-R7)
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 9; k++) begin
                logic [7:0] c;
                c = consts[k];
                wr(word(c, 2'(m), c));
                check("R10 sweep", 32'(lut_entries), 32'(c) + 32'd1);
                for (int a = 0; a < 256; a++) begin
                    logic [23:0] col;
                    col = {8'(a) ^ c, ~8'(a), 8'(a + k)};
                    push({8'(a), col}, {ref_alpha(2'(m), c, 8'(a)), col}, pol_tag(2'(m)));
                end
            end
        end

        // R8: transfer lock on alpha and policy, size still writable
        wr(word(8'h40, 2'b01, 8'h10));
        xfer_active = 1'b1;
        wr(word(8'h90, 2'b10, 8'h22));
        check("R8 readback", cfg_rdata, word(8'h40, 2'b01, 8'h22));
        push(32'h7712_3456, 32'h4012_3456, "R8");
        xfer_active = 1'b0;

        // R9: table-load lock on size, alpha and policy writable
        lut_busy = 1'b1;
        wr(word(8'h33, 2'b10, 8'h99));
        check("R9 readback", cfg_rdata, word(8'h33, 2'b10, 8'h22));
        check("R9 entries", 32'(lut_entries), 32'h23);
        push(32'h80AB_CDEF, {ref_alpha(2'b10, 8'h33, 8'h80), 24'hABCDEF}, "R9");
        lut_busy = 1'b0;

        // Drain outstanding pixels (R11 no loss)
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R11 drained", 32'(out_valid), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule